// File: doc/BRIEF.md
# Chainable Synchronous Up/Down Binary Counter

The block is a presettable binary counter built from identical narrow stages. Each stage is four bits wide by default. All state bits change together on the rising clock edge. On each edge the counter does one of four things: it loads a parallel word, counts up, counts down, or holds. The input levels sampled at that edge decide which.

There are two active-low count enables:
- `cen_n` goes to every stage at once.
- `cen_fwd_n` enters only the lowest stage. It is also fed forward into the active-low terminal-count output `carry_n`.

Inside the chain, each stage's `carry_n` becomes the forward enable of the stage above it. A stage therefore advances on exactly the edge where every stage below it wraps. No extra gating is needed. The chain behaves as a single counter of `STAGE_W*STAGES` bits.

Load (`load_n`) is active low and synchronous, and it overrides counting. `rst_n` is the chip-level asynchronous reset; it clears the count.

All pins are plain levels. The block has no streaming data path, so it carries no valid/ready handshake and applies no back-pressure.

Top module: `updn_chain`

## Requirements
- R1: While `rst_n` is low, `count` is zero.
- R2: When `load_n` is low at a rising edge, `count` takes `pdata` at that edge. This holds whatever the levels of `cen_n`, `cen_fwd_n` and `dir_up`.
- R3: When `load_n`, `cen_n` and `cen_fwd_n` are all at the counting levels (load high, both enables low) and `dir_up` is 1, `count` increases by one at the edge. It wraps from all ones to zero.
- R4: With the same load and enable levels and `dir_up` at 0, `count` decreases by one at the edge. It wraps from zero to all ones.
- R5: When `load_n` is high and either `cen_n` or `cen_fwd_n` is high, `count` keeps its value.
- R6: `carry_n` is low exactly when both of these hold:
  - `cen_fwd_n` is low.
  - `count` is all ones with `dir_up`=1, or zero with `dir_up`=0.

  It is decoded in the same cycle, with no register.
- R7: The chained stages act as one wide counter. A stage steps only on the edge where every lower stage wraps, and all bits change on the same edge.
- R8: Changes on `load_n`, `cen_n`, `cen_fwd_n`, `dir_up` or `pdata` that are undone before the next rising edge leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low, clears the count |
| load_n | input | 1 | Synchronous parallel load, active low |
| cen_n | input | 1 | Count enable to all stages, active low |
| cen_fwd_n | input | 1 | Count enable into the lowest stage, fed forward to the carry, active low |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| pdata | input | STAGE_W*STAGES | Parallel load word |
| count | output | STAGE_W*STAGES | Present count |
| carry_n | output | 1 | Terminal-count output, active low |

## Verification
Directed steps check each of the following:
- Load priority, using a load made while both enables are high.
- Wrap in each direction, starting from all ones going up and from zero going down.
- Carry from the low stage into the next, starting from a word whose low nibble is full.
- Carry masking, with the forward enable high while the count sits at the terminal value.

A seeded random stream then biases the enables toward counting and mixes in rare loads and direction changes. Every cycle is compared against a wide behavioural counter, which separates faults in stage chaining from faults in a single stage. A final test flips the controls mid-cycle and restores them before the edge, to show that only the levels at the edge matter.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } step_op_e;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic     load_n,
  input  logic     cen_n,
  input  logic     cen_fwd_n,
  input  logic     dir_up,
  output step_op_e op
);
  // Load overrides counting; either enable high freezes the stage.
  always_comb begin
    if (!load_n)                op = OP_LOAD;
    else if (cen_n || cen_fwd_n) op = OP_HOLD;
    else if (dir_up)            op = OP_INC;
    else                        op = OP_DEC;
  end
endmodule

// File: rtl/updn_tc.sv
module updn_tc #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         dir_up,
  input  logic         cen_fwd_n,
  output logic         carry_n
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic at_end;

  // Terminal value depends on direction: all ones going up, zero going down.
  assign at_end  = dir_up ? (q == TOP) : (q == '0);
  assign carry_n = ~(~cen_fwd_n & at_end);
endmodule

// File: rtl/updn_stage.sv
module updn_stage
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         cen_n,
  input  logic         cen_fwd_n,
  input  logic         dir_up,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry_n
);
  step_op_e     op;
  logic [W-1:0] q_nxt;

  updn_ctrl u_ctrl (
    .load_n    (load_n),
    .cen_n     (cen_n),
    .cen_fwd_n (cen_fwd_n),
    .dir_up    (dir_up),
    .op        (op)
  );

  updn_tc #(.W(W)) u_tc (
    .q         (q),
    .dir_up    (dir_up),
    .cen_fwd_n (cen_fwd_n),
    .carry_n   (carry_n)
  );

  always_comb begin
    unique case (op)
      OP_LOAD: q_nxt = din;
      OP_INC:  q_nxt = q + 1'b1;
      OP_DEC:  q_nxt = q - 1'b1;
      default: q_nxt = q;
    endcase
  end

  // One register for all bits: every bit changes on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (q == $past(din)));

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cen_n && !cen_fwd_n && dir_up) |=> (q == W'($past(q) + 1'b1)));

  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !cen_n && !cen_fwd_n && !dir_up) |=> (q == W'($past(q) - 1'b1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && (cen_n || cen_fwd_n)) |=> $stable(q));
endmodule

// File: rtl/updn_chain.sv
module updn_chain #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_n,
  input  logic                       cen_n,
  input  logic                       cen_fwd_n,
  input  logic                       dir_up,
  input  logic [STAGE_W*STAGES-1:0]  pdata,
  output logic [STAGE_W*STAGES-1:0]  count,
  output logic                       carry_n
);
  localparam int W = STAGE_W * STAGES;

  // fwd[k] is the forward enable into stage k; fwd[STAGES] is the chain carry.
  logic [STAGES:0] fwd;
  assign fwd[0] = cen_fwd_n;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    updn_stage #(.W(STAGE_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_n    (load_n),
      .cen_n     (cen_n),
      .cen_fwd_n (fwd[k]),
      .dir_up    (dir_up),
      .din       (pdata[k*STAGE_W +: STAGE_W]),
      .q         (count[k*STAGE_W +: STAGE_W]),
      .carry_n   (fwd[k+1])
    );
  end

  assign carry_n = fwd[STAGES];

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (count == '0));

  p_fwd_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cen_fwd_n |-> carry_n);

  p_full_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_fwd_n && dir_up && (count == {W{1'b1}})) |-> !carry_n);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_n && load_n && !cen_n) |=> (count == {W{~$past(dir_up)}}));
endmodule

// File: tb/updn_chain_bench.sv
module updn_chain_bench;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int W  = SW * NS;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic         cen_n = 1'b1;
  logic         cen_fwd_n = 1'b1;
  logic         dir_up = 1'b1;
  logic [W-1:0] pdata = '0;
  logic [W-1:0] count;
  logic         carry_n;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] mdl = '0;
  string prev_tag = "R1";

  always #5 clk = ~clk;

  updn_chain #(.STAGE_W(SW), .STAGES(NS)) u_updn_chain (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cen_n(cen_n),
    .cen_fwd_n(cen_fwd_n), .dir_up(dir_up), .pdata(pdata),
    .count(count), .carry_n(carry_n)
  );

  function automatic logic [W-1:0] f_next(logic [W-1:0] q, logic ld, logic cp,
                                          logic ct, logic up, logic [W-1:0] d);
    if (!ld) return d;
    if (cp || ct) return q;
    return up ? q + 1'b1 : q - 1'b1;
  endfunction

  function automatic logic f_carry(logic [W-1:0] q, logic ct, logic up);
    logic term;
    term = up ? (q == {W{1'b1}}) : (q == '0);
    return !(!ct && term);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, then check the state left by the last rising edge.
  task automatic step(logic ld, logic cp, logic ct, logic up, logic [W-1:0] d, string tag);
    @(negedge clk);
    load_n = ld; cen_n = cp; cen_fwd_n = ct; dir_up = up; pdata = d;
    #1;
    chk(prev_tag, count, mdl);
    chk("R6", {{(W-1){1'b0}}, carry_n}, {{(W-1){1'b0}}, f_carry(mdl, ct, up)});
    mdl = f_next(mdl, ld, cp, ct, up, d);
    prev_tag = tag;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1 chk("R1", count, '0);
    rst_n = 1'b1;
    // R2: load with both enables high
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'hFFF, "R2");
    // R3: wrap all ones -> zero; carry low here (R6)
    step(1'b1, 1'b0, 1'b0, 1'b1, 12'h123, "R3");
    // R5: hold with forward enable high; R6 carry masked
    step(1'b1, 1'b0, 1'b1, 1'b0, 12'h000, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'h000, "R2");
    // R4: wrap zero -> all ones
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'hABC, "R4");
    step(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFF, "R2");
    // R6: terminal count but forward enable high
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R6");
    // R7: low stage full, carry into the next stage
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'h0EF, "R2");
    step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R7");
    // R7: seeded random stream against the wide model
    for (int i = 0; i < 3000; i++) begin
      logic ld, cp, ct, up;
      ld = ($urandom % 16) != 0;
      cp = ($urandom % 8) == 0;
      ct = ($urandom % 8) == 0;
      up = ($urandom % 64) < 40 ? dir_up : ~dir_up;
      if (i % 500 == 0) step(1'b0, 1'b0, 1'b0, up, (i % 1000 == 0) ? 12'hFF0 : 12'h00F, "R7");
      else step(ld, cp, ct, up, W'($urandom), "R7");
    end
    // R8: controls flip mid-cycle and are restored before the edge
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R8");
    @(negedge clk);
    #1 chk(prev_tag, count, mdl);
    load_n = 1'b0; cen_n = 1'b0; cen_fwd_n = 1'b0; pdata = 12'h5A5;
    #2;
    load_n = 1'b1; cen_n = 1'b1; cen_fwd_n = 1'b1; pdata = 12'h000;
    @(negedge clk);
    #1 chk("R8", count, mdl);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule